// File: doc/BRIEF.md
# Unframed PN-11 Alarm-Indication Defect Monitor

This block watches a recovered serial bit stream, one bit per strobe, for the unframed alarm-indication signal. That signal is a pseudo-random PN-11 sequence built from the polynomial 1 + x^9 + x^11. The monitor drives one defect flag. It raises the flag after the pattern has been present for several consecutive measurement windows. It drops the flag after the pattern has been absent for the same number of windows.

The incoming bits pass through a feed-forward inverse of the PN-11 generator. Each output bit is the current line bit XOR the line bits from 9 and from 11 strobes earlier. A true PN-11 line drives this output to all zeros. A dead line of constant zeros does the same, so the block also counts ones on the raw line. It treats a window as alarm-like only when the raw line is busy and the inverse output is quiet. Windows are contiguous blocks of accepted bits. A small persistence stage turns the per-window verdicts into the flag.

Top module: `pn11_ais_monitor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) forces ais_defect low. It also clears the history bits, the partial window and the streak count, so that declaring again needs N_CONSEC full windows after reset.
- R2: The inverse output for each accepted bit is bit_in XOR the accepted bits from TAP_A and TAP_B strobes earlier (9 and 11 by default). A line that obeys a[n] = a[n-9] XOR a[n-11] therefore yields zero output ones once 11 bits are in history.
- R3: A window is exactly WIN_LEN accepted bits (default 8192). Windows are back to back. Both ones counts restart at every window boundary.
- R4: A window is alarm-like when its inverse-output ones count is below THRESH (default 256) and its raw-input ones count is at least THRESH. The comparison uses the full count, including the last bit of the window.
- R5: While ais_defect is low, N_CONSEC (default 3) consecutive alarm-like windows raise ais_defect. It goes high at the clock edge that accepts the last bit of the final window.
- R6: While ais_defect is high, N_CONSEC consecutive windows that are not alarm-like lower ais_defect. It goes low at the clock edge that accepts the last bit of the final window.
- R7: A window that does not support the pending change restarts the streak, and so does every change of ais_defect. ais_defect changes at no other time than a window end.
- R8: An all-zeros line never produces an alarm-like window and never raises ais_defect.
- R9: On cycles with bit_vld low, bit_in is ignored. Such cycles neither advance the window nor shift the history.
- R10: Parameter values that are out of range stop elaboration. These are: WIN_LEN below 2, THRESH outside 1..WIN_LEN, N_CONSEC below 1, and taps that are not 1 <= TAP_A < TAP_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High on cycles that carry a line bit |
| bit_in | input | 1 | Recovered line bit |
| ais_defect | output | 1 | Alarm-indication defect flag, registered |

## Verification
The flag only moves at window ends. A fault in the window counter, the ones counters or the inverse taps therefore shows up at the latest N_CONSEC windows later, as a declare or clear one window early or late, or one that never happens. An error in how a single window is classified is seen when the flag fails to move at the third window. A streak that does not restart is seen when a mixed run of windows ends with the flag high or low when it should be the other way. The bench places deliberate bit errors in PN-11 windows so that the inverse output sits just below and just above THRESH. It also inserts long runs of idle strobes, resets in the middle of a window, and runs of zeros. This brings internal miscounts out at ais_defect.

// File: rtl/pn11_ais_pkg.sv
`timescale 1ns/1ps
package pn11_ais_pkg;
   typedef enum logic {
      DEF_CLEAR    = 1'b0,
      DEF_DECLARED = 1'b1
   } defect_state_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pn11_inv_descrambler.sv
`timescale 1ns/1ps
module pn11_inv_descrambler #(
   parameter int unsigned TAP_A = 9,
   parameter int unsigned TAP_B = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic bit_in,
   output logic desc_bit
);
   localparam int unsigned DEPTH = TAP_B;

   logic [DEPTH-1:0] hist;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
      end else if (bit_vld) begin
         hist <= {hist[DEPTH-2:0], bit_in};
      end
   end

   // hist[k-1] holds the accepted bit from k strobes ago
   assign desc_bit = bit_in ^ hist[TAP_A-1] ^ hist[TAP_B-1];
endmodule

// File: rtl/pn11_win_counter.sv
`timescale 1ns/1ps
module pn11_win_counter #(
   parameter int unsigned WIN_LEN = 8192,
   localparam int unsigned CW = $clog2(WIN_LEN + 1),
   localparam int unsigned BW = pn11_ais_pkg::width_of(WIN_LEN)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bit_vld,
   input  logic          raw_bit,
   input  logic          desc_bit,
   output logic          win_end,
   output logic [BW-1:0] bit_cnt,
   output logic [CW-1:0] in_final,
   output logic [CW-1:0] out_final
);
   localparam logic [BW-1:0] LAST_IDX = BW'(WIN_LEN - 1);
   localparam bit IS_POW2 = ((WIN_LEN & (WIN_LEN - 1)) == 0);

   logic [CW-1:0] in_cnt;
   logic [CW-1:0] out_cnt;

   generate
      if (IS_POW2) begin : g_wrap
         assign win_end = bit_vld && (&bit_cnt);
         always_ff @(posedge clk) begin
            if (rst)          bit_cnt <= '0;
            else if (bit_vld) bit_cnt <= bit_cnt + 1'b1;
         end
      end else begin : g_cmp
         assign win_end = bit_vld && (bit_cnt == LAST_IDX);
         always_ff @(posedge clk) begin
            if (rst)          bit_cnt <= '0;
            else if (win_end) bit_cnt <= '0;
            else if (bit_vld) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   endgenerate

   assign in_final  = in_cnt  + {{(CW-1){1'b0}}, (bit_vld & raw_bit)};
   assign out_final = out_cnt + {{(CW-1){1'b0}}, (bit_vld & desc_bit)};

   always_ff @(posedge clk) begin
      if (rst || win_end) begin
         in_cnt  <= '0;
         out_cnt <= '0;
      end else begin
         in_cnt  <= in_final;
         out_cnt <= out_final;
      end
   end
endmodule

// File: rtl/pn11_persist.sv
`timescale 1ns/1ps
module pn11_persist #(
   parameter int unsigned N_CONSEC = 3,
   localparam int unsigned SW = pn11_ais_pkg::width_of(N_CONSEC)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          win_end,
   input  logic          alarm_like,
   output logic          defect,
   output logic [SW-1:0] streak
);
   import pn11_ais_pkg::*;

   localparam logic [SW-1:0] LAST_S = SW'(N_CONSEC - 1);

   defect_state_e state;
   logic          wants_flip;

   // a window supports a change when its verdict differs from the current flag
   assign wants_flip = (alarm_like != (state == DEF_DECLARED));
   assign defect     = (state == DEF_DECLARED);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= DEF_CLEAR;
         streak <= '0;
      end else if (win_end) begin
         if (!wants_flip) begin
            streak <= '0;
         end else if (streak == LAST_S) begin
            state  <= (state == DEF_CLEAR) ? DEF_DECLARED : DEF_CLEAR;
            streak <= '0;
         end else begin
            streak <= streak + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pn11_ais_monitor.sv
`timescale 1ns/1ps
module pn11_ais_monitor #(
   parameter int unsigned WIN_LEN  = 8192,
   parameter int unsigned THRESH   = 256,
   parameter int unsigned N_CONSEC = 3,
   parameter int unsigned TAP_A    = 9,
   parameter int unsigned TAP_B    = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic bit_in,
   output logic ais_defect
);
   localparam int unsigned CW = $clog2(WIN_LEN + 1);
   localparam int unsigned BW = pn11_ais_pkg::width_of(WIN_LEN);
   localparam int unsigned SW = pn11_ais_pkg::width_of(N_CONSEC);
   localparam logic [CW-1:0] TH_V = CW'(THRESH);

   // R10: elaboration-time parameter checks
   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (THRESH < 1 || THRESH > WIN_LEN) begin : g_bad_th
         $error("THRESH must lie in 1..WIN_LEN");
      end
      if (N_CONSEC < 1) begin : g_bad_n
         $error("N_CONSEC must be at least 1");
      end
      if (TAP_A < 1 || TAP_B <= TAP_A) begin : g_bad_tap
         $error("taps must satisfy 1 <= TAP_A < TAP_B");
      end
   endgenerate

   logic          desc_bit;
   logic          win_end;
   logic [BW-1:0] bit_cnt;
   logic [CW-1:0] in_final;
   logic [CW-1:0] out_final;
   logic          alarm_like;
   logic [SW-1:0] streak;

   pn11_inv_descrambler #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_inv (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
      .desc_bit(desc_bit)
   );

   pn11_win_counter #(.WIN_LEN(WIN_LEN)) u_win (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .raw_bit(bit_in),
      .desc_bit(desc_bit), .win_end(win_end), .bit_cnt(bit_cnt),
      .in_final(in_final), .out_final(out_final)
   );

   assign alarm_like = (out_final < TH_V) && (in_final >= TH_V);

   pn11_persist #(.N_CONSEC(N_CONSEC)) u_pers (
      .clk(clk), .rst(rst), .win_end(win_end), .alarm_like(alarm_like),
      .defect(ais_defect), .streak(streak)
   );
endmodule

// File: rtl/pn11_ais_monitor_chk.sv
`timescale 1ns/1ps
module pn11_ais_monitor_chk #(
   parameter int unsigned WIN_LEN  = 8192,
   parameter int unsigned N_CONSEC = 3,
   parameter int unsigned CW = 14,
   parameter int unsigned BW = 13,
   parameter int unsigned SW = 2
) (
   input logic          clk,
   input logic          rst,
   input logic          bit_vld,
   input logic          ais_defect,
   input logic          win_end,
   input logic          alarm_like,
   input logic [BW-1:0] bit_cnt,
   input logic [CW-1:0] in_final,
   input logic [SW-1:0] streak
);
   assert_rst_clears_R1: assert property (@(posedge clk) rst |=> !ais_defect);

   assert_flag_moves_at_window_end_R7: assert property (@(posedge clk) disable iff (rst)
      !win_end |=> $stable(ais_defect));

   assert_streak_bounded_R7: assert property (@(posedge clk) disable iff (rst)
      32'(streak) < N_CONSEC);

   assert_window_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
      32'(bit_cnt) < WIN_LEN);

   assert_window_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
      win_end |-> bit_vld);

   assert_zero_line_not_alarm_R8: assert property (@(posedge clk) disable iff (rst)
      (win_end && in_final == '0) |-> !alarm_like);

   assert_no_declare_without_alarm_R5: assert property (@(posedge clk) disable iff (rst)
      (win_end && !ais_defect && !alarm_like) |=> !ais_defect);

   assert_no_clear_on_alarm_R6: assert property (@(posedge clk) disable iff (rst)
      (win_end && ais_defect && alarm_like) |=> ais_defect);
endmodule

bind pn11_ais_monitor pn11_ais_monitor_chk #(
   .WIN_LEN(WIN_LEN), .N_CONSEC(N_CONSEC), .CW(CW), .BW(BW), .SW(SW)
) u_chk (
   .clk(clk), .rst(rst), .bit_vld(bit_vld), .ais_defect(ais_defect),
   .win_end(win_end), .alarm_like(alarm_like), .bit_cnt(bit_cnt),
   .in_final(in_final), .streak(streak)
);

// File: tb/pn11_ais_monitor_bench.sv
`timescale 1ns/1ps
module pn11_ais_monitor_bench;
   localparam int WIN = 1024;
   localparam int TH  = 32;
   localparam int NC  = 3;

   localparam int K_PN   = 0;
   localparam int K_RAND = 1;
   localparam int K_ZERO = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic ais_defect;

   int n_checks = 0;
   int n_fail = 0;

   // reference state, derived from the requirements
   logic [10:0] m_hist;
   int m_in, m_out, m_idx, m_streak;
   logic m_def;
   logic [10:0] pn_gen = 11'h5A5;

   always #5 clk = ~clk;

   pn11_ais_monitor #(.WIN_LEN(WIN), .THRESH(TH), .N_CONSEC(NC)) u_pn11_ais_monitor (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
      .ais_defect(ais_defect)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: ais_defect=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic window_alarm(input int ones_in, input int ones_out);
      return (ones_out < TH) && (ones_in >= TH);
   endfunction

   task automatic model_reset();
      m_hist = '0; m_in = 0; m_out = 0; m_idx = 0; m_streak = 0; m_def = 1'b0;
   endtask

   task automatic model_bit(input logic b);
      logic o;
      logic al;
      o = b ^ m_hist[8] ^ m_hist[10];
      m_hist = {m_hist[9:0], b};
      m_in += int'(b);
      m_out += int'(o);
      m_idx++;
      if (m_idx == WIN) begin
         al = window_alarm(m_in, m_out);
         if (al != m_def) begin
            if (m_streak == NC - 1) begin m_def = !m_def; m_streak = 0; end
            else m_streak++;
         end else m_streak = 0;
         m_in = 0; m_out = 0; m_idx = 0;
      end
   endtask

   function automatic logic pn_next();
      logic nb;
      nb = pn_gen[8] ^ pn_gen[10];
      pn_gen = {pn_gen[9:0], nb};
      return nb;
   endfunction

   task automatic push(input logic b);
      if ($urandom_range(7) == 0) begin
         @(negedge clk); bit_vld = 1'b0; bit_in = 1'($urandom);  // R9 idle strobe
      end
      @(negedge clk); bit_vld = 1'b1; bit_in = b;
      model_bit(b);
   endtask

   // nerr > 0: flip PN bits at offsets 100 + 50*k, each adding 3 output ones
   task automatic send_window(input int kind, input int nerr, input string req);
      for (int i = 0; i < WIN; i++) begin
         logic b;
         case (kind)
            K_PN:    b = pn_next();
            K_RAND:  b = 1'($urandom);
            default: b = 1'b0;
         endcase
         if (kind == K_PN && i >= 100 && (i - 100) % 50 == 0 && (i - 100) / 50 < nerr)
            b = !b;
         push(b);
      end
      @(posedge clk); #1;
      check(ais_defect, m_def, req);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; bit_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();
      #1 check(ais_defect, 1'b0, "R1 reset state");

      // R5/R2: clean PN-11 declares at the third window
      send_window(K_PN, 0, "R2 pn window 1");
      check(ais_defect, 1'b0, "R5 no declare after 1");
      send_window(K_PN, 0, "R5 pn window 2");
      check(ais_defect, 1'b0, "R5 no declare after 2");
      send_window(K_PN, 0, "R5 pn window 3");
      check(ais_defect, 1'b1, "R5 declare after 3");

      // R7: broken clear streak, then R6 clear
      send_window(K_RAND, 0, "R7 clear streak 1");
      send_window(K_RAND, 0, "R7 clear streak 2");
      send_window(K_PN, 0, "R7 streak restart");
      check(ais_defect, 1'b1, "R7 still declared");
      send_window(K_RAND, 0, "R6 clear 1");
      send_window(K_RAND, 0, "R6 clear 2");
      check(ais_defect, 1'b1, "R6 not yet cleared");
      send_window(K_RAND, 0, "R6 clear 3");
      check(ais_defect, 1'b0, "R6 cleared");

      // R8: all-zeros line
      for (int w = 0; w < 4; w++) send_window(K_ZERO, 0, "R8 zero line");
      check(ais_defect, 1'b0, "R8 zeros never declare");

      // R9: long idle stretch does not advance the window
      send_window(K_PN, 0, "R9 pn before idle 1");
      send_window(K_PN, 0, "R9 pn before idle 2");
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk); bit_vld = 1'b0; bit_in = 1'b1;
      end
      #1 check(ais_defect, 1'b0, "R9 idle has no effect");
      send_window(K_PN, 0, "R9 pn after idle");
      check(ais_defect, 1'b1, "R3 declare on third full window");

      // R1: reset mid-window clears partial counts and streak
      for (int i = 0; i < 500; i++) push(pn_next());
      do_reset();
      #1 check(ais_defect, 1'b0, "R1 reset drops flag");
      send_window(K_PN, 0, "R1 after reset 1");
      send_window(K_PN, 0, "R1 after reset 2");
      check(ais_defect, 1'b0, "R1 streak cleared by reset");
      send_window(K_PN, 0, "R1 after reset 3");
      check(ais_defect, 1'b1, "R1 declare after full windows");

      // R4 boundary: 11 errors give 33 output ones (not alarm), 10 give 30
      send_window(K_PN, 0, "R4 clean lead-in");
      for (int w = 0; w < 3; w++) send_window(K_PN, 11, "R4 above threshold");
      check(ais_defect, 1'b0, "R4 33 ones clears");
      for (int w = 0; w < 3; w++) send_window(K_PN, 10, "R4 below threshold");
      check(ais_defect, 1'b1, "R4 30 ones declares");

      // mixed random windows against the reference
      for (int w = 0; w < 10; w++) begin
         int k;
         k = int'($urandom_range(3));
         if (k == 3) send_window(K_PN, 10 + int'($urandom_range(1)), "R4 random mix");
         else send_window(k, 0, "R4 random mix");
      end

      @(negedge clk); bit_vld = 1'b0;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule